// File: doc/BRIEF.md
# Macroblock Hadamard Cost Accumulator

This block scores one candidate prediction of a 16×16 macroblock. It takes the residual (original minus prediction) as a stream of signed samples and returns one unsigned cost per macroblock. A mode-decision stage compares these costs across the prediction modes it tries. One cost is produced for each prediction mode of each macroblock.

The macroblock arrives as sixteen 4×4 sub-blocks. Each sub-block passes through a two-dimensional 4×4 Hadamard transform built from row and column butterflies, with no scaling. The magnitudes of its fifteen non-DC coefficients are added to a running total. The sixteen DC terms are stored in a 4×4 grid, one entry per sub-block position. After the last sub-block, the grid passes through a second 4×4 Hadamard transform, and the magnitudes of all sixteen results are added to give the final cost. A synchronous clear restarts collection at a macroblock boundary.

Top module: `mb_hadamard_cost`

## Requirements
- R1: While reset is active, and afterwards until the first result, `cost` is 0 and `done` is 0.
- R2: A sample is taken only in a cycle with `in_valid` high. Cycles with `in_valid` low, whatever `in_res` holds, leave the result unchanged.
- R3: Sample order is fixed. Samples 16k to 16k+15 form sub-block k. Within a sub-block, sample 4r+c sits at row r, column c. Sub-block k sits at grid row k/4, grid column k%4 of the macroblock.
- R4: For each sub-block, the unnormalised 4×4 Hadamard is applied, and the absolute values of all coefficients except the DC term (the sum of all sixteen samples) are added to the cost.
- R5: The sixteen DC terms, placed at their sub-block grid positions, go through a second unnormalised 4×4 Hadamard. The absolute values of all sixteen of its outputs, DC included, are added to the cost.
- R6: `done` is high for exactly one cycle, two clock edges after the edge that takes the 256th sample. `cost` takes the new value on that same edge and holds it until the next `done`.
- R7: `clr` high at a clock edge discards any partly received macroblock and any result not yet delivered. The sample offered in that cycle is also discarded. `cost` keeps its value.
- R8: Residuals at the extremes of the input range (-256 and 255 at the default width) give the exact cost, with no wrap in the 24-bit output.
- R9: Macroblocks may follow one another with no gap and no `clr`. Each result covers only its own 256 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous restart at a macroblock boundary |
| in_valid | input | 1 | `in_res` carries a sample this cycle |
| in_res | input | IN_W (9) | Signed residual sample |
| cost | output | COST_W (24) | Unsigned cost of the last completed macroblock |
| done | output | 1 | One-cycle pulse when `cost` is updated |

## Verification
The overflow checks assume that every residual fits the signed input width. They also assume that the sub-block index and the grid entry advance only in strict arrival order, so that the second-level transform starts only on the cycle after the sixteenth sub-block completes. The stimulus draws samples from the full signed 9-bit range, including the two extreme values and a checkerboard of them that drives the cost towards its maximum. It inserts idle cycles carrying junk data, and it asserts `clr` mid-macroblock and in both cycles of the gap between the last sample and the result, which exercises every restart path.

// File: rtl/hc_pkg.sv
package hc_pkg;
   localparam int HC_SIDE        = 4;
   localparam int HC_N           = HC_SIDE * HC_SIDE;
   localparam int HC_NBLK        = 16;
   localparam int HC_CNT_W       = $clog2(HC_N);
   localparam int HC_IDX_W       = $clog2(HC_NBLK);
   localparam int HC_GROWTH      = 2 * $clog2(HC_SIDE);
   localparam int HC_SUM_GROWTH  = $clog2(HC_N);
endpackage

// File: rtl/hc_blk_buf.sv
module hc_blk_buf import hc_pkg::*; #(
   parameter int IW = 9
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  in_valid,
   input  logic signed [IW-1:0]  in_res,
   output logic                  blk_vld,
   output logic [HC_N*IW-1:0]    blk_flat
);
   if (IW < 2) begin : g_bad_iw
      $error("hc_blk_buf: IW must be at least 2");
   end

   logic [HC_CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         blk_vld  <= 1'b0;
         blk_flat <= '0;
      end else if (clr) begin
         cnt      <= '0;
         blk_vld  <= 1'b0;
      end else begin
         blk_vld <= in_valid && (cnt == HC_CNT_W'(HC_N - 1));
         if (in_valid) begin
            blk_flat[int'(cnt)*IW +: IW] <= in_res;
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_BLK_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      blk_vld |-> $past(in_valid && !clr));  // R2
endmodule

// File: rtl/hc_had4.sv
module hc_had4 import hc_pkg::*; #(
   parameter int IW = 9,
   parameter int OW = IW + 4
) (
   input  logic [HC_N*IW-1:0] x,
   output logic [HC_N*OW-1:0] y
);
   if (OW < IW + HC_GROWTH) begin : g_bad_ow
      $error("hc_had4: OW too narrow for unnormalised gain");
   end

   logic signed [OW-1:0] a [HC_N];
   logic signed [OW-1:0] m [HC_N];
   logic signed [OW-1:0] z [HC_N];

   for (genvar i = 0; i < HC_N; i++) begin : g_io
      assign a[i]          = OW'($signed(x[i*IW +: IW]));
      assign y[i*OW +: OW] = z[i];
   end

   // horizontal butterflies
   for (genvar r = 0; r < HC_SIDE; r++) begin : g_row
      logic signed [OW-1:0] s0, s1, d0, d1;
      assign s0 = a[r*HC_SIDE+0] + a[r*HC_SIDE+1];
      assign s1 = a[r*HC_SIDE+2] + a[r*HC_SIDE+3];
      assign d0 = a[r*HC_SIDE+0] - a[r*HC_SIDE+1];
      assign d1 = a[r*HC_SIDE+2] - a[r*HC_SIDE+3];
      assign m[r*HC_SIDE+0] = s0 + s1;
      assign m[r*HC_SIDE+1] = s0 - s1;
      assign m[r*HC_SIDE+2] = d0 + d1;
      assign m[r*HC_SIDE+3] = d0 - d1;
   end

   // vertical butterflies; element 0 ends up as the DC term
   for (genvar c = 0; c < HC_SIDE; c++) begin : g_col
      logic signed [OW-1:0] s0, s1, d0, d1;
      assign s0 = m[0*HC_SIDE+c] + m[1*HC_SIDE+c];
      assign s1 = m[2*HC_SIDE+c] + m[3*HC_SIDE+c];
      assign d0 = m[0*HC_SIDE+c] - m[1*HC_SIDE+c];
      assign d1 = m[2*HC_SIDE+c] - m[3*HC_SIDE+c];
      assign z[0*HC_SIDE+c] = s0 + s1;
      assign z[1*HC_SIDE+c] = s0 - s1;
      assign z[2*HC_SIDE+c] = d0 + d1;
      assign z[3*HC_SIDE+c] = d0 - d1;
   end
endmodule

// File: rtl/hc_abssum.sv
module hc_abssum import hc_pkg::*; #(
   parameter int W       = 13,
   parameter int SUM_W   = W + 4,
   parameter bit SKIP_DC = 1'b1
) (
   input  logic [HC_N*W-1:0] c_flat,
   output logic [SUM_W-1:0]  sum
);
   if (SUM_W < W + HC_SUM_GROWTH) begin : g_bad_sw
      $error("hc_abssum: SUM_W too narrow");
   end

   logic [W-1:0] mag [HC_N];

   for (genvar i = 0; i < HC_N; i++) begin : g_mag
      logic signed [W-1:0] c;
      assign c = c_flat[i*W +: W];
      if (SKIP_DC && i == 0) begin : g_skip
         assign mag[i] = '0;
      end else begin : g_keep
         assign mag[i] = c[W-1] ? W'(-c) : W'(c);
      end
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < HC_N; i++) sum = sum + SUM_W'(mag[i]);
   end
endmodule

// File: rtl/mb_hadamard_cost.sv
module mb_hadamard_cost import hc_pkg::*; #(
   parameter int IN_W   = 9,
   parameter int COST_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_res,
   output logic [COST_W-1:0]       cost,
   output logic                    done
);
   localparam int C1_W = IN_W + HC_GROWTH;
   localparam int C2_W = C1_W + HC_GROWTH;
   localparam int S1_W = C1_W + HC_SUM_GROWTH;
   localparam int S2_W = C2_W + HC_SUM_GROWTH;

   if (COST_W < S2_W) begin : g_bad_cost_w
      $error("mb_hadamard_cost: COST_W cannot hold worst-case cost");
   end

   logic                    blk_vld;
   logic [HC_N*IN_W-1:0]    blk_flat;
   logic [HC_N*C1_W-1:0]    c1_flat;
   logic [HC_N*C1_W-1:0]    dc_flat;
   logic [HC_N*C2_W-1:0]    c2_flat;
   logic [S1_W-1:0]         ac_sum;
   logic [S2_W-1:0]         l2_sum;
   logic [HC_IDX_W-1:0]     blk_idx;
   logic                    l2_go;
   logic [COST_W-1:0]       acc;
   logic [COST_W:0]         acc_ac_nxt;
   logic [COST_W:0]         acc_l2_nxt;

   hc_blk_buf #(.IW(IN_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
      .in_res(in_res), .blk_vld(blk_vld), .blk_flat(blk_flat));

   hc_had4 #(.IW(IN_W), .OW(C1_W)) u_had_sub (.x(blk_flat), .y(c1_flat));

   hc_abssum #(.W(C1_W), .SUM_W(S1_W), .SKIP_DC(1'b1)) u_sum_ac (
      .c_flat(c1_flat), .sum(ac_sum));

   hc_had4 #(.IW(C1_W), .OW(C2_W)) u_had_dc (.x(dc_flat), .y(c2_flat));

   hc_abssum #(.W(C2_W), .SUM_W(S2_W), .SKIP_DC(1'b0)) u_sum_dc (
      .c_flat(c2_flat), .sum(l2_sum));

   assign acc_ac_nxt = {1'b0, acc} + (COST_W+1)'(ac_sum);
   assign acc_l2_nxt = {1'b0, acc} + (COST_W+1)'(l2_sum);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         cost    <= '0;
         done    <= 1'b0;
         blk_idx <= '0;
         l2_go   <= 1'b0;
         dc_flat <= '0;
      end else begin
         done <= 1'b0;
         if (clr) begin
            acc     <= '0;
            blk_idx <= '0;
            l2_go   <= 1'b0;
            dc_flat <= '0;
         end else begin
            l2_go <= blk_vld && (blk_idx == HC_IDX_W'(HC_NBLK - 1));
            if (blk_vld) begin
               acc     <= acc_ac_nxt[COST_W-1:0];
               dc_flat[int'(blk_idx)*C1_W +: C1_W] <= c1_flat[C1_W-1:0];
               blk_idx <= blk_idx + 1'b1;
            end
            if (l2_go) begin
               cost <= acc_l2_nxt[COST_W-1:0];
               done <= 1'b1;
               acc  <= '0;
            end
         end
      end
   end

   AST_NO_OVERFLOW_AC: assert property (@(posedge clk) disable iff (!rst_n)
      blk_vld |-> !acc_ac_nxt[COST_W]);  // R8
   AST_NO_OVERFLOW_L2: assert property (@(posedge clk) disable iff (!rst_n)
      l2_go |-> !acc_l2_nxt[COST_W]);  // R8
   AST_L2_AFTER_BLK: assert property (@(posedge clk) disable iff (!rst_n)
      l2_go |-> $past(blk_vld));  // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R6
   AST_COST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(cost));  // R6
   AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (blk_idx == '0 && !l2_go && !done && !blk_vld));  // R7
endmodule

// File: tb/tb_mb_hadamard_cost.sv
module tb_mb_hadamard_cost;
   logic              clk = 1'b0;
   logic              rst_n, clr, in_valid;
   logic signed [8:0] in_res;
   logic [23:0]       cost;
   logic              done;

   int total = 0, bad = 0, cyc = 0;
   bit ended = 1'b0;
   string tag = "R1";

   logic        exp_done = 1'b0;
   logic [23:0] exp_cost = '0;
   int mb_q[$];
   int pend_cyc[$];
   int pend_cost[$];

   always #4 clk = ~clk;

   mb_hadamard_cost dut (.clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
                         .in_res(in_res), .cost(cost), .done(done));

   function automatic int hs(int u, int i);
      return ($countones(u & i) % 2) ? -1 : 1;
   endfunction

   function automatic int iabs(int v);
      return v < 0 ? -v : v;
   endfunction

   function automatic int model_cost(int v[256]);
      int dc[16];
      int tot = 0;
      for (int b = 0; b < 16; b++)
         for (int u = 0; u < 4; u++)
            for (int w = 0; w < 4; w++) begin
               int c = 0;
               for (int i = 0; i < 4; i++)
                  for (int j = 0; j < 4; j++)
                     c += hs(u, i) * hs(w, j) * v[b*16 + i*4 + j];
               if (u == 0 && w == 0) dc[b] = c; else tot += iabs(c);
            end
      for (int u = 0; u < 4; u++)
         for (int w = 0; w < 4; w++) begin
            int c = 0;
            for (int i = 0; i < 4; i++)
               for (int j = 0; j < 4; j++)
                  c += hs(u, i) * hs(w, j) * dc[i*4 + j];
            tot += iabs(c);
         end
      return tot;
   endfunction

   task automatic finish_up();
      if (!ended) begin
         ended = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // reference model, advanced on each rising edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         mb_q.delete(); pend_cyc.delete(); pend_cost.delete();
         exp_done = 1'b0; exp_cost = '0;
      end else if (clr) begin
         mb_q.delete(); pend_cyc.delete(); pend_cost.delete();
         exp_done = 1'b0;
      end else begin
         exp_done = 1'b0;
         if (pend_cyc.size() > 0 && pend_cyc[0] == cyc) begin
            exp_done = 1'b1;
            exp_cost = 24'(pend_cost[0]);
            void'(pend_cyc.pop_front());
            void'(pend_cost.pop_front());
         end
         if (in_valid) begin
            mb_q.push_back(int'(in_res));
            if (mb_q.size() == 256) begin
               int arr[256];
               for (int k = 0; k < 256; k++) arr[k] = mb_q[k];
               pend_cyc.push_back(cyc + 2);
               pend_cost.push_back(model_cost(arr));
               mb_q.delete();
            end
         end
      end
      if (cyc >= 100000) begin
         bad++;
         $display("FAIL watchdog: act=hung exp=finished");
         finish_up();
      end
   end

   // compare on every falling edge
   always @(negedge clk) if (!ended) begin
      total++;
      if (done !== exp_done) begin
         bad++;
         $display("FAIL R6 (%s) done: act=%0b exp=%0b", tag, done, exp_done);
      end
      total++;
      if (cost !== exp_cost) begin
         bad++;
         $display("FAIL %s cost: act=%0d exp=%0d", tag, cost, exp_cost);
      end
   end

   task automatic put(bit v, bit c, int d);
      @(negedge clk);
      in_valid = v; clr = c; in_res = d[8:0];
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) put(1'b0, 1'b0, int'($urandom_range(0, 511)));
   endtask

   function automatic int gen(int kind, int s);
      int b = s / 16, p = s % 16;
      int row = (b / 4) * 4 + p / 4, col = (b % 4) * 4 + p % 4;
      case (kind)
         0: return 0;
         1: return 5;
         2: return int'($urandom_range(0, 511)) - 256;
         3: return ((s * 37) % 512) - 256;
         4: return -256;
         default: return ((row + col) % 2) ? 255 : -256;
      endcase
   endfunction

   task automatic send_mb(int kind, bit gaps);
      for (int s = 0; s < 256; s++) begin
         if (gaps) idle(int'($urandom_range(0, 2)));
         put(1'b1, 1'b0, gen(kind, s));
      end
   endtask

   initial begin
      rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; in_res = '0;
      tag = "R1"; repeat (4) @(negedge clk);
      rst_n = 1'b1; idle(3);
      tag = "R4 zero";       send_mb(0, 1'b0); idle(4);
      tag = "R5 const";      send_mb(1, 1'b0); idle(4);
      tag = "R3 positional"; send_mb(3, 1'b0); idle(4);
      tag = "R9 back2back";  send_mb(2, 1'b0); send_mb(2, 1'b0); send_mb(3, 1'b0); idle(4);
      tag = "R2 bubbles";    send_mb(2, 1'b1); idle(4);
      tag = "R8 negmax";     send_mb(4, 1'b0); idle(4);
      tag = "R8 checker";    send_mb(5, 1'b0); idle(4);
      tag = "R7 mid clear";
      for (int s = 0; s < 100; s++) put(1'b1, 1'b0, gen(2, s));
      put(1'b1, 1'b1, 77);
      send_mb(2, 1'b0); idle(4);
      tag = "R7 clear gap1"; send_mb(2, 1'b0); put(1'b0, 1'b1, 0); idle(5);
      tag = "R7 clear gap2"; send_mb(2, 1'b0); idle(1); put(1'b0, 1'b1, 0); idle(5);
      tag = "R7 after clear"; send_mb(3, 1'b0); idle(5);
      finish_up();
   end
endmodule